// File: doc/BRIEF.md
# Digital Automatic Level Control and Peak Limiter

This block steers the gain code of a stereo programmable-gain amplifier from the samples that the amplifier produces. Each sample strobe gives one signed left sample and one signed right sample. The block compares the magnitude of each sample with a target level. When the signal stays loud it lowers the gain code, and when the signal stays quiet it raises the code again. Each channel holds a 7-bit gain code in half-decibel steps. Code 42 is 0 dB, and code n stands for (n − 42) × 0.5 dB, so the range is 0 (−21 dB) to 90 (+24 dB).

A function select picks between two behaviours. The first is a peak limiter that acts on both channels. It can ignore short bursts through a transient window, and it only brings the gain back up to 0 dB. The second is automatic level control, which acts on the left channel, the right channel or both. It has a hold time before the gain starts to rise, it can raise the gain to the top of the range, and it has a noise gate that freezes the gain during near-silence. All timing is counted in sample strobes. The attack and decay periods double with each step of their code, and the doubling stops at code 10.

Top module: `alc_limiter`

## Requirements
- R1: While reset is active, and after it is released, both gain codes read 42 (0 dB). Code n means (n − 42) × 0.5 dB, and valid codes run from 0 to 90.
- R2: While `ctl_enable` is 0, both gain codes stay where they are and every internal count is cleared.
- R3: `ctl_func` selects the behaviour: 2'b00 limiter on both channels, 2'b01 level control on the right channel only (left code frozen), 2'b10 level control on the left channel only (right code frozen), 2'b11 level control on both channels.
- R4: A sample is over threshold when its magnitude exceeds 2^(SMP_W−2) >> (15 − `ctl_target`). A channel lowers its code by one after every run of L consecutive counted over-threshold samples. L = base << min(`ctl_attack`, 10), where the base is ALC_ATK_BASE in level-control mode and LIM_ATK_BASE in limiter mode. The most negative sample counts as over threshold.
- R5: In level-control mode, once a channel has seen `ctl_hold` × HOLD_BASE consecutive under-threshold samples, it raises its code by one after every further run of D such samples. D = ALC_DCY_BASE << min(`ctl_decay`, 10).
- R6: In limiter mode there is no hold time. The code rises by one per LIM_DCY_BASE << min(`ctl_decay`, 10) under-threshold samples, but only while it is below 42. A code at or above 42 never rises in limiter mode.
- R7: In limiter mode, the first `ctl_window` × WIN_BASE samples of a run of over-threshold samples are ignored by the attack timer. Any under-threshold sample restarts that window.
- R8: In level-control mode with `gate_enable` set, an under-threshold sample whose magnitude is below 2^(SMP_W−1) >> (`gate_level` + GATE_OFS) leaves the code, the hold count and the decay count unchanged. The gate has no effect in limiter mode.
- R9: The gain code saturates at 0 and at 90 and never wraps.
- R10: An under-threshold sample restarts the attack count. An over-threshold sample restarts the hold count and the decay count.
- R11: In a cycle where `smp_valid` is low, neither gain code changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_valid | input | 1 | One-cycle strobe marking a new sample pair |
| smp_l | input | SMP_W | Left sample, two's complement |
| smp_r | input | SMP_W | Right sample, two's complement |
| ctl_enable | input | 1 | Enables gain control |
| ctl_func | input | 2 | Behaviour select (see R3) |
| ctl_target | input | 4 | Target level, 6 dB per step |
| ctl_attack | input | 4 | Attack period code |
| ctl_decay | input | 4 | Decay period code |
| ctl_hold | input | 4 | Hold length before the gain rises (level control) |
| ctl_window | input | 3 | Transient window length (limiter) |
| gate_enable | input | 1 | Noise gate enable (level control) |
| gate_level | input | 3 | Noise gate threshold, 6 dB per step below full scale |
| gain_l | output | GAIN_W | Left gain code |
| gain_r | output | GAIN_W | Right gain code |

## Verification
The bench drives five kinds of stimulus:
- Steady loud samples pull the code down to the floor, which separates the attack period and its code saturation from the floor clamp.
- Steady moderate samples show the hold delay, and then the decay ramp up to either the 0 dB ceiling or the top of the range, depending on the mode.
- Short bursts separated by a single quiet sample leave the gain unchanged, and this only works if the transient window and the attack and hold restarts behave as specified.
- Near-silence is used in both modes to set the noise-gate freeze apart from ordinary decay.
- Running the single-channel modes shows that the unselected channel stays frozen.

A behavioural model predicts both codes on every clock.

// File: rtl/alc_pkg.sv
package alc_pkg;

  typedef enum logic [1:0] {
    FN_LIMIT  = 2'b00,
    FN_ALC_R  = 2'b01,
    FN_ALC_L  = 2'b10,
    FN_ALC_ST = 2'b11
  } alc_fn_e;

  // Time codes above this value behave as this value.
  localparam logic [3:0] CODE_CAP = 4'd10;

  function automatic logic [3:0] cap_code(input logic [3:0] code);
    return (code > CODE_CAP) ? CODE_CAP : code;
  endfunction

endpackage

// File: rtl/alc_rst_sync.sv
module alc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/alc_peak_cmp.sv
module alc_peak_cmp #(
  parameter int SMP_W = 24
) (
  input  logic signed [SMP_W-1:0] sample,
  input  logic        [SMP_W-1:0] thr_over,
  input  logic        [SMP_W-1:0] thr_gate,
  output logic                    over,
  output logic                    quiet
);
  logic [SMP_W-1:0] mag;

  // Unsigned magnitude; the most negative value maps to 2^(SMP_W-1).
  always_comb begin
    mag   = sample[SMP_W-1] ? (~sample + 1'b1) : sample;
    over  = mag > thr_over;
    quiet = mag < thr_gate;
  end
endmodule

// File: rtl/alc_counter.sv
module alc_counter #(
  parameter int W        = 8,
  parameter bit SATURATE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  generate
    if (SATURATE) begin : g_sat
      // Persistence counter: hit once limit events have been seen.
      always_comb begin
        hit    = cnt_q >= limit;
        cnt_en = clr | (inc & ~hit);
        cnt_d  = clr ? '0 : cnt_q + W'(1);
      end
    end else begin : g_tmr
      // Period timer: hit on the event that completes the period.
      logic [W:0] cnt_inc;
      always_comb begin
        cnt_inc = {1'b0, cnt_q} + (W+1)'(1);
        hit     = inc & (cnt_inc >= {1'b0, limit});
        cnt_en  = clr | inc;
        cnt_d   = (clr | hit) ? '0 : cnt_inc[W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/alc_chan.sv
module alc_chan #(
  parameter int GAIN_W   = 7,
  parameter int GAIN_MAX = 90,
  parameter int GAIN_NOM = 42,
  parameter int TIM_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              step,
  input  logic              lim,
  input  logic              gate_en,
  input  logic              over,
  input  logic              quiet,
  input  logic [TIM_W-1:0]  atk_len,
  input  logic [TIM_W-1:0]  dcy_len,
  input  logic [TIM_W-1:0]  hold_len,
  input  logic [TIM_W-1:0]  win_len,
  output logic [GAIN_W-1:0] gain
);
  localparam logic [GAIN_W-1:0] CODE_MAX = GAIN_W'(GAIN_MAX);
  localparam logic [GAIN_W-1:0] CODE_NOM = GAIN_W'(GAIN_NOM);

  logic [GAIN_W-1:0] gain_q, gain_d, ceil_code;
  logic              gain_en;
  logic smp_over, smp_under, gated, below_ceil, rise_ok;
  logic win_hit, hold_hit, atk_fire, dcy_fire;
  logic win_clr, win_inc, atk_clr, atk_inc;
  logic hold_clr, hold_inc, dcy_clr, dcy_inc;

  always_comb begin
    smp_over   = active & step & over;
    smp_under  = active & step & ~over;
    gated      = ~lim & gate_en & quiet;
    ceil_code  = lim ? CODE_NOM : CODE_MAX;
    below_ceil = gain_q < ceil_code;
    rise_ok    = smp_under & ~gated & (lim | hold_hit);

    win_clr  = ~active | smp_under;
    win_inc  = smp_over & lim;
    atk_clr  = ~active | smp_under;
    atk_inc  = smp_over & (~lim | win_hit);
    hold_clr = ~active | smp_over;
    hold_inc = smp_under & ~gated & ~lim;
    dcy_clr  = ~active | smp_over | (rise_ok & ~below_ceil);
    dcy_inc  = rise_ok & below_ceil;
  end

  alc_counter #(.W(TIM_W), .SATURATE(1'b1)) u_win (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .inc(win_inc),
    .limit(win_len), .hit(win_hit));

  alc_counter #(.W(TIM_W), .SATURATE(1'b0)) u_atk (
    .clk(clk), .rst_n(rst_n), .clr(atk_clr), .inc(atk_inc),
    .limit(atk_len), .hit(atk_fire));

  alc_counter #(.W(TIM_W), .SATURATE(1'b1)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(hold_clr), .inc(hold_inc),
    .limit(hold_len), .hit(hold_hit));

  alc_counter #(.W(TIM_W), .SATURATE(1'b0)) u_dcy (
    .clk(clk), .rst_n(rst_n), .clr(dcy_clr), .inc(dcy_inc),
    .limit(dcy_len), .hit(dcy_fire));

  // Next gain: one code down on attack expiry (floor 0), one up on decay.
  always_comb begin
    gain_en = 1'b0;
    gain_d  = gain_q;
    if (atk_fire && gain_q != '0) begin
      gain_en = 1'b1;
      gain_d  = gain_q - 1'b1;
    end else if (dcy_fire) begin
      gain_en = 1'b1;
      gain_d  = gain_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gain_q <= CODE_NOM;
    else if (gain_en) gain_q <= gain_d;
  end

  assign gain = gain_q;
endmodule

// File: rtl/alc_limiter.sv
module alc_limiter #(
  parameter int SMP_W        = 24,
  parameter int GAIN_W       = 7,
  parameter int GAIN_MAX     = 90,
  parameter int GAIN_NOM     = 42,
  parameter int ALC_ATK_BASE = 100,
  parameter int ALC_DCY_BASE = 1608,
  parameter int LIM_ATK_BASE = 12,
  parameter int LIM_DCY_BASE = 58,
  parameter int HOLD_BASE    = 96,
  parameter int WIN_BASE     = 24,
  parameter int GATE_OFS     = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_l,
  input  logic signed [SMP_W-1:0] smp_r,
  input  logic                    ctl_enable,
  input  logic [1:0]              ctl_func,
  input  logic [3:0]              ctl_target,
  input  logic [3:0]              ctl_attack,
  input  logic [3:0]              ctl_decay,
  input  logic [3:0]              ctl_hold,
  input  logic [2:0]              ctl_window,
  input  logic                    gate_enable,
  input  logic [2:0]              gate_level,
  output logic [GAIN_W-1:0]       gain_l,
  output logic [GAIN_W-1:0]       gain_r
);
  import alc_pkg::*;

  localparam int BASE_A   = (ALC_ATK_BASE > ALC_DCY_BASE) ? ALC_ATK_BASE : ALC_DCY_BASE;
  localparam int BASE_B   = (LIM_ATK_BASE > LIM_DCY_BASE) ? LIM_ATK_BASE : LIM_DCY_BASE;
  localparam int BASE_C   = (HOLD_BASE > WIN_BASE) ? HOLD_BASE : WIN_BASE;
  localparam int BASE_AB  = (BASE_A > BASE_B) ? BASE_A : BASE_B;
  localparam int BASE_MAX = (BASE_AB > BASE_C) ? BASE_AB : BASE_C;
  localparam int TIM_W    = $clog2(BASE_MAX + 1) + 12;
  localparam int NCH      = 2;
  localparam logic [SMP_W-1:0] HALF_SCALE = SMP_W'(1) << (SMP_W-2);
  localparam logic [SMP_W-1:0] FULL_SCALE = SMP_W'(1) << (SMP_W-1);

  logic                    rst_n_int;
  logic                    lim;
  logic [SMP_W-1:0]        thr_over, thr_gate;
  logic [5:0]              gate_shift;
  logic [TIM_W-1:0]        atk_len, dcy_len, hold_len, win_len;
  logic signed [SMP_W-1:0] smp_ch  [NCH];
  logic [GAIN_W-1:0]       gain_ch [NCH];

  alc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  // Shared thresholds and period lengths derived from the controls.
  always_comb begin
    lim        = (alc_fn_e'(ctl_func) == FN_LIMIT);
    thr_over   = HALF_SCALE >> (4'd15 - ctl_target);
    gate_shift = 6'(gate_level) + 6'(GATE_OFS);
    thr_gate   = FULL_SCALE >> gate_shift;
    atk_len    = (lim ? TIM_W'(LIM_ATK_BASE) : TIM_W'(ALC_ATK_BASE)) << cap_code(ctl_attack);
    dcy_len    = (lim ? TIM_W'(LIM_DCY_BASE) : TIM_W'(ALC_DCY_BASE)) << cap_code(ctl_decay);
    hold_len   = TIM_W'(ctl_hold) * TIM_W'(HOLD_BASE);
    win_len    = TIM_W'(ctl_window) * TIM_W'(WIN_BASE);
  end

  assign smp_ch[0] = smp_l;
  assign smp_ch[1] = smp_r;

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam alc_fn_e MONO_FN = (c == 0) ? FN_ALC_L : FN_ALC_R;
      logic over, quiet, active;

      assign active = ctl_enable &
                      ((alc_fn_e'(ctl_func) == FN_LIMIT)  |
                       (alc_fn_e'(ctl_func) == FN_ALC_ST) |
                       (alc_fn_e'(ctl_func) == MONO_FN));

      alc_peak_cmp #(.SMP_W(SMP_W)) u_cmp (
        .sample(smp_ch[c]), .thr_over(thr_over), .thr_gate(thr_gate),
        .over(over), .quiet(quiet));

      alc_chan #(.GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX), .GAIN_NOM(GAIN_NOM),
                 .TIM_W(TIM_W)) u_chan (
        .clk(clk), .rst_n(rst_n_int), .active(active), .step(smp_valid),
        .lim(lim), .gate_en(gate_enable), .over(over), .quiet(quiet),
        .atk_len(atk_len), .dcy_len(dcy_len), .hold_len(hold_len),
        .win_len(win_len), .gain(gain_ch[c]));
    end
  endgenerate

  assign gain_l = gain_ch[0];
  assign gain_r = gain_ch[1];
endmodule

// File: rtl/alc_limiter_chk.sv
module alc_limiter_chk #(
  parameter int GAIN_W   = 7,
  parameter int GAIN_MAX = 90,
  parameter int GAIN_NOM = 42
) (
  input logic              clk,
  input logic              rst_n,
  input logic              smp_valid,
  input logic              ctl_enable,
  input logic [1:0]        ctl_func,
  input logic [GAIN_W-1:0] gain_l,
  input logic [GAIN_W-1:0] gain_r
);
  // R9
  gain_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_l <= GAIN_W'(GAIN_MAX)) && (gain_r <= GAIN_W'(GAIN_MAX)));

  // R11
  idle_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> ($stable(gain_l) && $stable(gain_r)));

  // R2
  disabled_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> ($stable(gain_l) && $stable(gain_r)));

  // R3
  right_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_func == 2'b01) |=> $stable(gain_l));

  // R3
  left_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_func == 2'b10) |=> $stable(gain_r));

  // R4
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_l != $past(gain_l)) |->
      ((gain_l == $past(gain_l) + 1'b1) || (gain_l == $past(gain_l) - 1'b1)));

  // R6
  limiter_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_func == 2'b00) && (gain_r >= GAIN_W'(GAIN_NOM))) |=> (gain_r <= $past(gain_r)));
endmodule

bind alc_limiter alc_limiter_chk #(
  .GAIN_W(GAIN_W), .GAIN_MAX(GAIN_MAX), .GAIN_NOM(GAIN_NOM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .ctl_enable(ctl_enable),
  .ctl_func(ctl_func), .gain_l(gain_l), .gain_r(gain_r)
);

// File: tb/tb_alc_limiter.sv
`timescale 1ns/1ps
module tb_alc_limiter;
  localparam int W = 24, GW = 7, GMAX = 90, GNOM = 42;
  localparam int AA = 2, AD = 4, LA = 1, LD = 2, HB = 2, WB = 2, GO = 12;
  localparam int LOUD = 3000000, QUIET = 5000, HUSH = 100, MOSTNEG = -8388608;

  logic clk, rst_n, smp_valid, ctl_enable, gate_enable;
  logic signed [W-1:0] smp_l, smp_r;
  logic [1:0] ctl_func;
  logic [3:0] ctl_target, ctl_attack, ctl_decay, ctl_hold;
  logic [2:0] ctl_window, gate_level;
  logic [GW-1:0] gain_l, gain_r;

  alc_limiter #(.SMP_W(W), .GAIN_W(GW), .GAIN_MAX(GMAX), .GAIN_NOM(GNOM),
    .ALC_ATK_BASE(AA), .ALC_DCY_BASE(AD), .LIM_ATK_BASE(LA), .LIM_DCY_BASE(LD),
    .HOLD_BASE(HB), .WIN_BASE(WB), .GATE_OFS(GO)) dut (.*);

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit run_cmp = 0, done = 0;
  int mg[2], m_atk[2], m_dcy[2], m_hold[2], m_win[2];

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int span(input int base, input int code);
    return base * (1 << ((code > 10) ? 10 : code));
  endfunction

  // Behavioural reference: per-channel sample counts and code, per the requirements.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        mg[c] = GNOM; m_atk[c] = 0; m_dcy[c] = 0; m_hold[c] = 0; m_win[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit act, lim, over, gated;
        longint v, mag, thr, gthr;
        int ceil;
        lim = (ctl_func == 2'b00);
        act = ctl_enable && (lim || ctl_func == 2'b11 ||
              (c == 0 && ctl_func == 2'b10) || (c == 1 && ctl_func == 2'b01));
        if (!act) begin
          m_atk[c] = 0; m_dcy[c] = 0; m_hold[c] = 0; m_win[c] = 0;
        end else if (smp_valid) begin
          v    = (c == 0) ? longint'(smp_l) : longint'(smp_r);
          mag  = (v < 0) ? -v : v;
          thr  = (longint'(1) << (W - 2)) >> (15 - ctl_target);
          gthr = (longint'(1) << (W - 1)) >> (gate_level + GO);
          over = mag > thr;
          if (over) begin
            m_dcy[c] = 0; m_hold[c] = 0;
            if (lim && m_win[c] < ctl_window * WB) m_win[c]++;
            else begin
              m_atk[c]++;
              if (m_atk[c] >= span(lim ? LA : AA, ctl_attack)) begin
                m_atk[c] = 0;
                if (mg[c] > 0) mg[c]--;
              end
            end
          end else begin
            m_atk[c] = 0; m_win[c] = 0;
            gated = !lim && gate_enable && (mag < gthr);
            if (!gated) begin
              if (!lim && m_hold[c] < ctl_hold * HB) m_hold[c]++;
              else begin
                ceil = lim ? GNOM : GMAX;
                if (mg[c] < ceil) begin
                  m_dcy[c]++;
                  if (m_dcy[c] >= span(lim ? LD : AD, ctl_decay)) begin
                    m_dcy[c] = 0; mg[c]++;
                  end
                end else m_dcy[c] = 0;
              end
            end
          end
        end
      end
    end
  end

  // Per-clock comparison against the reference.
  always @(negedge clk) begin
    if (run_cmp && !done) begin
      checks++;
      if (gain_l !== GW'(mg[0]) || gain_r !== GW'(mg[1])) begin
        fails++;
        $display("FAIL %s: gain_l/gain_r = %0d/%0d, expected %0d/%0d",
                 cur_req, gain_l, gain_r, mg[0], mg[1]);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input int l, input int r, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b1; smp_l = l[W-1:0]; smp_r = r[W-1:0];
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 190000);
    fails++;
    $display("FAIL watchdog: run did not end, actual timeout, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; smp_valid = 0; smp_l = '0; smp_r = '0;
    ctl_enable = 0; ctl_func = 2'b11; ctl_target = 4'b1011;
    ctl_attack = 0; ctl_decay = 0; ctl_hold = 0; ctl_window = 0;
    gate_enable = 0; gate_level = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset left", gain_l, 42);
    chk("R1 reset right", gain_r, 42);
    rst_n = 1;
    repeat (4) @(negedge clk);
    run_cmp = 1;

    // R2: disabled, loud input
    cur_req = "R2";
    drive(LOUD, -LOUD, 20, 1);
    chk("R2 left frozen", gain_l, 42);
    chk("R2 right frozen", gain_r, 42);

    // R11: loud data without strobe
    cur_req = "R11";
    ctl_enable = 1;
    smp_l = LOUD; smp_r = LOUD;
    repeat (30) @(negedge clk);
    chk("R11 no strobe", gain_l, 42);

    // R7: limiter, bursts inside a 4-sample window are ignored
    cur_req = "R7";
    ctl_func = 2'b00; ctl_attack = 0; ctl_decay = 3; ctl_window = 2;
    for (int k = 0; k < 6; k++) begin
      drive(LOUD, -LOUD, 4, 0);
      drive(QUIET, QUIET, 1, 0);
    end
    chk("R7 burst ignored", gain_l, 42);
    drive(LOUD, -LOUD, 5, 0);
    chk("R7 fifth over sample acts", gain_r, 41);

    // R4: limiter attack, one code per sample
    cur_req = "R4";
    drive(LOUD, -LOUD, 20, 1);
    chk("R4 limiter attack", gain_l, 21);

    // R6: limiter decay stops at 0 dB
    cur_req = "R6";
    ctl_decay = 0;
    drive(QUIET, QUIET, 60, 0);
    chk("R6 limiter ceiling", gain_l, 42);

    // R4: attack code above 10 behaves as 10 (1024 samples)
    cur_req = "R4";
    ctl_attack = 15; ctl_window = 0;
    drive(LOUD, LOUD, 1023, 0);
    chk("R4 capped code, before", gain_l, 42);
    drive(LOUD, LOUD, 1, 0);
    chk("R4 capped code, after", gain_l, 41);

    // R9: level control saturates at the floor
    cur_req = "R9";
    ctl_func = 2'b11; ctl_attack = 0;
    drive(LOUD, MOSTNEG, 200, 0);
    chk("R9 floor left", gain_l, 0);
    chk("R9 floor right", gain_r, 0);

    // R5: hold of 6 samples, then one step per 4 samples
    cur_req = "R5";
    ctl_hold = 3;
    drive(QUIET, QUIET, 9, 0);
    chk("R5 still held", gain_l, 0);
    drive(QUIET, QUIET, 1, 0);
    chk("R5 first rise", gain_l, 1);
    cur_req = "R9";
    drive(QUIET, QUIET, 400, 0);
    chk("R9 ceiling", gain_r, 90);

    // R6: limiter never raises a code above 0 dB
    cur_req = "R6";
    ctl_func = 2'b00;
    drive(QUIET, QUIET, 20, 0);
    chk("R6 above nominal kept", gain_l, 90);
    drive(LOUD, LOUD, 50, 0);
    drive(QUIET, QUIET, 30, 0);
    chk("R6 returns to nominal", gain_l, 42);

    // R8: gate freezes level control, ignored by limiter
    cur_req = "R8";
    ctl_func = 2'b11;
    drive(LOUD, LOUD, 10, 0);
    gate_enable = 1; gate_level = 0;
    drive(HUSH, HUSH, 60, 0);
    chk("R8 gated hold", gain_l, 37);
    ctl_func = 2'b00;
    drive(HUSH, HUSH, 20, 0);
    chk("R8 ignored in limiter", gain_l, 42);
    gate_enable = 0;

    // R3: single-channel modes
    cur_req = "R3";
    ctl_func = 2'b01;
    drive(LOUD, LOUD, 20, 0);
    chk("R3 left frozen", gain_l, 42);
    chk("R3 right active", gain_r, 32);
    ctl_func = 2'b10;
    drive(LOUD, LOUD, 10, 0);
    chk("R3 left active", gain_l, 37);
    chk("R3 right frozen", gain_r, 32);

    // R10: alternating runs restart the counts
    cur_req = "R10";
    ctl_func = 2'b11; ctl_attack = 3; ctl_hold = 15;
    for (int k = 0; k < 10; k++) begin
      drive(LOUD, MOSTNEG, 10, 0);
      drive(QUIET, QUIET, 1, 0);
    end
    chk("R10 left steady", gain_l, 37);
    chk("R10 right steady", gain_r, 32);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule